// File: doc/BRIEF.md
# Shadow Memory Region Attribute Controller

This block holds the memory-configuration registers of a 386-class system controller. It turns them into access attributes for the top half of the first megabyte. Software writes 16-bit words to a small set of I/O-mapped registers. For each 20-bit memory address, the block reports where a read is served and where a write goes. A read is served either by on-board DRAM or by the external bus. A write goes to DRAM or to the external bus, or it is dropped.

There are two region layouts. The coarse layout has four 128 KB windows above 0x80000, each driven by fields of the control register. The fine layout has eight 32 KB windows from 0xC0000 upward, each with its own enable bit and read-only bit. A sticky lock bit freezes every region attribute. The write that sets the lock is itself still applied, and in that write any enabled ROM shadow becomes read-only. A status pin reports whether the 32 KB window at the selected system-ROM base is shadowed.

The register port and the address lookup are plain control paths with no flow control. A write is taken on any clock edge where `cfg_we` is high, and the read data follows `cfg_addr` combinationally.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: After reset, the register at I/O 0x28 reads 0x00F9 and every other implemented register reads 0. Every address at or above 0x80000 maps to the external bus for both reads and writes, and the configuration is unlocked.
- R2: Attribute encoding: `rd_ext` is 1 for the external bus and 0 for DRAM. `wr_dst` is 0 for DRAM, 1 for the external bus and 2 for a dropped write. Addresses below 0x80000 always give `rd_ext`=0 and `wr_dst`=0.
- R3: In coarse mode (bit 0 of register 0x2C clear), a write to register 0x22 with bit 3 set maps 0x80000-0x9FFFF to DRAM for reads and writes. With bit 3 clear, that window maps external for both.
- R4: In coarse mode, bit 10 of register 0x22 shadows 0xA0000-0xBFFFF. Bit 11 then makes the window writable (set) or read-only with writes dropped (clear). With bit 10 clear, the window is external for both.
- R5: In coarse mode, bit 9 of register 0x22 shadows 0xC0000-0xDFFFF and bit 0 shadows 0xE0000-0xFFFFF. While the lock bit is clear, these shadows are read/write.
- R6: Bit 15 of register 0x22 is a lock that stays set until reset. In the write that sets it, any enabled ROM shadow (bit 9 or bit 0) reads from DRAM with writes dropped. After that write, no register write changes any attribute.
- R7: In fine mode (bit 0 of register 0x2C set), a write to register 0x2E sets window i (base 0xC0000 + i*0x8000, i = 0..7). Bit i+8 enables the window and bit i selects read-only (set) or read/write (clear). A disabled window is external for both. Writes to 0x22 change no attribute in fine mode, and writes to 0x2E change none in coarse mode.
- R8: `bios_shadowed` is 1 when the 32 KB window at the ROM base is served by DRAM for reads. The ROM base is 0xE0000 if bit 8 of register 0x22 is set and 0xF0000 otherwise.
- R9: The implemented registers are 0x22, 0x24, 0x26, 0x28, 0x2A, 0x2C and 0x2E. Each reads back the last value written, including while locked. Writes to any other I/O address are ignored, and reads from any other address return 0.
- R10: The attribute outputs depend combinationally on `mem_addr`. A register write changes them from the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register I/O address (write and read) |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| mem_addr | input | 20 | Memory address to classify |
| rd_ext | output | 1 | 1: read served by external bus, 0: DRAM |
| wr_dst | output | 2 | 0: DRAM, 1: external bus, 2: dropped |
| bios_shadowed | output | 1 | ROM-base window is shadowed |

## Verification
A register write is taken at one rising edge. The attribute, status and read-back outputs reflect it as soon as that edge has passed, and the address lookup adds no cycle. The driver changes inputs only on falling edges. The probe for each address or register is applied one falling edge before the rising edge after which the monitor compares, so every compare sits at least one full register stage after the write it depends on. Lock and mode cases are probed before and after each write, so a frozen or ignored write shows up as unchanged attributes at the ports.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [1:0] {
    WR_INT  = 2'd0,
    WR_EXT  = 2'd1,
    WR_DROP = 2'd2
  } wr_dst_e;

  typedef struct packed {
    logic    rd_ext;
    wr_dst_e wr;
  } slot_attr_t;

  localparam int ATTR_W = $bits(slot_attr_t);

  localparam slot_attr_t ATTR_EXT = '{rd_ext: 1'b1, wr: WR_EXT};
  localparam slot_attr_t ATTR_RW  = '{rd_ext: 1'b0, wr: WR_INT};
  localparam slot_attr_t ATTR_RO  = '{rd_ext: 1'b0, wr: WR_DROP};

  // Control register (0x22) field positions
  localparam int CTL_SYS_EN  = 0;
  localparam int CTL_BASE640 = 3;
  localparam int CTL_ROM_LO  = 8;
  localparam int CTL_OPT_EN  = 9;
  localparam int CTL_VID_EN  = 10;
  localparam int CTL_VID_WR  = 11;
  localparam int CTL_LOCK    = 15;
  // Granularity register (0x2C)
  localparam int GRAN_FINE   = 0;

  function automatic slot_attr_t shadow_attr(input logic en, input logic ro);
    if (!en)     return ATTR_EXT;
    else if (ro) return ATTR_RO;
    else         return ATTR_RW;
  endfunction

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_pkg::*;
#(
  parameter int IO_AW    = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 7,
  parameter int BASE     = 'h22,
  parameter int STRIDE   = 2,
  parameter int RST_IDX  = 3,
  parameter int RST_VAL  = 'h00F9,
  parameter int IDX_CTL  = 0,
  parameter int IDX_GRAN = 5,
  parameter int IDX_FINE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IO_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [DATA_W-1:0] gran_q,
  output logic [DATA_W-1:0] ctl_q,
  output logic              wr_ctl,
  output logic              wr_fine,
  output logic              locked_q
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_dec
      localparam logic [IO_AW-1:0] REG_ADDR = IO_AW'(BASE + gi * STRIDE);
      assign hit[gi] = (cfg_addr == REG_ADDR);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs_q[i] <= (i == RST_IDX) ? DATA_W'(RST_VAL) : '0;
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (hit[i]) regs_q[i] <= cfg_wdata;
    end
  end

  // Sticky lock: set by a control write carrying the lock bit
  always_ff @(posedge clk) begin
    if (!rst_n)
      locked_q <= 1'b0;
    else if (cfg_we && hit[IDX_CTL] && cfg_wdata[CTL_LOCK])
      locked_q <= 1'b1;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit[i]) cfg_rdata = regs_q[i];
  end

  assign ctl_q   = regs_q[IDX_CTL];
  assign gran_q  = regs_q[IDX_GRAN];
  assign wr_ctl  = cfg_we && hit[IDX_CTL];
  assign wr_fine = cfg_we && hit[IDX_FINE];

endmodule

// File: rtl/shadow_attr_plan.sv
module shadow_attr_plan
  import shadow_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_SLOTS = 16
) (
  input  logic                        upd_coarse,
  input  logic                        upd_fine,
  input  logic [DATA_W-1:0]           wdata,
  input  slot_attr_t [NUM_SLOTS-1:0]  slots_q,
  output slot_attr_t [NUM_SLOTS-1:0]  slots_d
);

  localparam int QUARTER    = NUM_SLOTS / 4;
  localparam int FINE_FIRST = NUM_SLOTS / 2;
  localparam int FINE_CNT   = NUM_SLOTS - FINE_FIRST;
  localparam int RO_OFS     = 0;
  localparam int EN_OFS     = DATA_W / 2;

  slot_attr_t coarse_attr [4];

  // One attribute per coarse window; the lock in the same write turns ROM shadows read-only
  always_comb begin
    coarse_attr[0] = wdata[CTL_BASE640] ? ATTR_RW : ATTR_EXT;
    coarse_attr[1] = shadow_attr(wdata[CTL_VID_EN], !wdata[CTL_VID_WR]);
    coarse_attr[2] = shadow_attr(wdata[CTL_OPT_EN], wdata[CTL_LOCK]);
    coarse_attr[3] = shadow_attr(wdata[CTL_SYS_EN], wdata[CTL_LOCK]);
  end

  genvar gs;
  generate
    for (gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
      if (gs >= FINE_FIRST && gs - FINE_FIRST < FINE_CNT) begin : g_fine
        localparam int FI = gs - FINE_FIRST;
        always_comb begin
          if (upd_coarse)
            slots_d[gs] = coarse_attr[gs / QUARTER];
          else if (upd_fine)
            slots_d[gs] = shadow_attr(wdata[EN_OFS + FI], wdata[RO_OFS + FI]);
          else
            slots_d[gs] = slots_q[gs];
        end
      end else begin : g_coarse_only
        always_comb begin
          if (upd_coarse) slots_d[gs] = coarse_attr[gs / QUARTER];
          else            slots_d[gs] = slots_q[gs];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/shadow_attr_store.sv
module shadow_attr_store
  import shadow_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SLOT_AW   = 15,
  parameter int NUM_SLOTS = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  slot_attr_t [NUM_SLOTS-1:0]  slots_d,
  output slot_attr_t [NUM_SLOTS-1:0]  slots_q,
  input  logic [ADDR_W-1:0]           mem_addr,
  input  logic                        rom_lo,
  output logic                        rd_ext,
  output logic [1:0]                  wr_dst,
  output logic                        bios_shadowed
);

  localparam int IDX_W       = ADDR_W - 1 - SLOT_AW;
  localparam int ROM_HI_SLOT = NUM_SLOTS - 2;
  localparam int ROM_LO_SLOT = NUM_SLOTS - 4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SLOTS; s++) slots_q[s] <= ATTR_EXT;
    end else begin
      slots_q <= slots_d;
    end
  end

  logic [IDX_W-1:0] slot_idx;
  slot_attr_t       hit_attr;

  assign slot_idx = mem_addr[ADDR_W-2:SLOT_AW];

  always_comb begin
    if (!mem_addr[ADDR_W-1]) hit_attr = ATTR_RW;
    else                     hit_attr = slots_q[slot_idx];
  end

  assign rd_ext        = hit_attr.rd_ext;
  assign wr_dst        = hit_attr.wr;
  assign bios_shadowed = rom_lo ? !slots_q[ROM_LO_SLOT].rd_ext
                                : !slots_q[ROM_HI_SLOT].rd_ext;

endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
  import shadow_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int IO_AW   = 8,
  parameter int DATA_W  = 16,
  parameter int SLOT_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IO_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              rd_ext,
  output logic [1:0]        wr_dst,
  output logic              bios_shadowed
);

  localparam int NUM_SLOTS = 2 ** (ADDR_W - 1 - SLOT_AW);

  logic [DATA_W-1:0] ctl_q, gran_q;
  logic wr_ctl, wr_fine, locked_q;
  logic upd_coarse, upd_fine;
  slot_attr_t [NUM_SLOTS-1:0] slots_q, slots_d;

  shadow_cfg_regs #(.IO_AW(IO_AW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .gran_q(gran_q),
    .ctl_q(ctl_q), .wr_ctl(wr_ctl), .wr_fine(wr_fine), .locked_q(locked_q)
  );

  assign upd_coarse = wr_ctl  && !locked_q && !gran_q[GRAN_FINE];
  assign upd_fine   = wr_fine && !locked_q &&  gran_q[GRAN_FINE];

  shadow_attr_plan #(.DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS)) u_plan (
    .upd_coarse(upd_coarse), .upd_fine(upd_fine), .wdata(cfg_wdata),
    .slots_q(slots_q), .slots_d(slots_d)
  );

  shadow_attr_store #(.ADDR_W(ADDR_W), .SLOT_AW(SLOT_AW), .NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .rst_n(rst_n), .slots_d(slots_d), .slots_q(slots_q),
    .mem_addr(mem_addr), .rom_lo(ctl_q[CTL_ROM_LO]), .rd_ext(rd_ext),
    .wr_dst(wr_dst), .bios_shadowed(bios_shadowed)
  );

endmodule

// File: rtl/shadow_attr_ctrl_chk.sv
module shadow_attr_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int IO_AW  = 8,
  parameter int DATA_W = 16,
  parameter int SLOTS_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              rd_ext,
  input logic [1:0]        wr_dst,
  input logic [IO_AW-1:0]  cfg_addr,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              locked,
  input logic [SLOTS_W-1:0] slots
);

  logic known_reg;
  assign known_reg = (cfg_addr >= IO_AW'('h22)) && (cfg_addr <= IO_AW'('h2E)) && !cfg_addr[0];

  p_low_internal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_addr[ADDR_W-1] |-> (rd_ext == 1'b0 && wr_dst == 2'd0));

  p_drop_only_shadowed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dst == 2'd2 |-> rd_ext == 1'b0);

  p_legal_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dst != 2'd3);

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  p_lock_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(slots));

  p_unknown_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !known_reg |-> cfg_rdata == '0);

endmodule

bind shadow_attr_ctrl shadow_attr_ctrl_chk #(
  .ADDR_W(ADDR_W), .IO_AW(IO_AW), .DATA_W(DATA_W),
  .SLOTS_W(NUM_SLOTS * shadow_pkg::ATTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .rd_ext(rd_ext),
  .wr_dst(wr_dst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .locked(locked_q), .slots(slots_q)
);

// File: tb/shadow_attr_ctrl_tb.sv
module shadow_attr_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [15:0] cfg_wdata = 16'h0;
  logic [15:0] cfg_rdata;
  logic [19:0] mem_addr = 20'h0;
  logic        rd_ext;
  logic [1:0]  wr_dst;
  logic        bios_shadowed;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_attr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_addr(mem_addr),
    .rd_ext(rd_ext), .wr_dst(wr_dst), .bios_shadowed(bios_shadowed)
  );

  typedef struct {
    int          kind;   // 0 attribute, 1 register read, 2 status
    logic        e_rd;
    logic [1:0]  e_wr;
    logic [15:0] e_data;
    logic        e_bios;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe_attr(input logic [19:0] a, input logic r, input logic [1:0] w, input string tag);
    exp_t e;
    @(negedge clk);
    mem_addr = a;
    e.kind = 0; e.e_rd = r; e.e_wr = w; e.e_data = '0; e.e_bios = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic probe_reg(input logic [7:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_addr = a;
    e.kind = 1; e.e_rd = 1'b0; e.e_wr = '0; e.e_data = d; e.e_bios = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic probe_bios(input logic b, input string tag);
    exp_t e;
    @(negedge clk);
    e.kind = 2; e.e_rd = 1'b0; e.e_wr = '0; e.e_data = '0; e.e_bios = b; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares one queued expectation per cycle, after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (e.kind == 0) begin
          if (rd_ext !== e.e_rd || wr_dst !== e.e_wr) begin
            n_fail++;
            $display("FAIL %s addr=%05h: rd_ext/wr_dst = %0b/%0d expected %0b/%0d",
                     e.tag, mem_addr, rd_ext, wr_dst, e.e_rd, e.e_wr);
          end
        end else if (e.kind == 1) begin
          if (cfg_rdata !== e.e_data) begin
            n_fail++;
            $display("FAIL %s reg=%02h: rdata = %04h expected %04h",
                     e.tag, cfg_addr, cfg_rdata, e.e_data);
          end
        end else begin
          if (bios_shadowed !== e.e_bios) begin
            n_fail++;
            $display("FAIL %s: bios_shadowed = %0b expected %0b",
                     e.tag, bios_shadowed, e.e_bios);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    probe_reg(8'h28, 16'h00F9, "R1");
    probe_reg(8'h22, 16'h0000, "R1");
    probe_attr(20'h90000, 1'b1, 2'd1, "R1");
    probe_attr(20'hE0000, 1'b1, 2'd1, "R1");
    probe_bios(1'b0, "R1");
    // R2 low memory always internal
    probe_attr(20'h12345, 1'b0, 2'd0, "R2");
    probe_attr(20'h7FFFF, 1'b0, 2'd0, "R2");

    // Coarse: base640, video RO, option, system shadows
    cfg_write(8'h22, 16'h0609);
    probe_attr(20'h85000, 1'b0, 2'd0, "R3");
    probe_attr(20'hA0000, 1'b0, 2'd2, "R4");
    probe_attr(20'hC8000, 1'b0, 2'd0, "R5");
    probe_attr(20'hF0000, 1'b0, 2'd0, "R5");
    probe_bios(1'b1, "R8");
    probe_attr(20'h00100, 1'b0, 2'd0, "R10");

    // Video writable, ROM shadows off
    cfg_write(8'h22, 16'h0C08);
    probe_attr(20'hBFFFF, 1'b0, 2'd0, "R4");
    probe_attr(20'hD0000, 1'b1, 2'd1, "R5");
    probe_attr(20'hFFFFF, 1'b1, 2'd1, "R5");
    probe_bios(1'b0, "R8");

    // Unimplemented address ignored
    cfg_write(8'h30, 16'hFFFF);
    probe_reg(8'h30, 16'h0000, "R9");
    probe_attr(20'hC0000, 1'b1, 2'd1, "R9");
    probe_reg(8'h22, 16'h0C08, "R9");

    // Fine mode (R7); 0x2E written in coarse mode first has no effect
    cfg_write(8'h2E, 16'hFF00);
    probe_attr(20'hC0000, 1'b1, 2'd1, "R7");
    cfg_write(8'h2C, 16'h0001);
    cfg_write(8'h2E, 16'h0F41);
    probe_attr(20'hC0000, 1'b0, 2'd2, "R7");
    probe_attr(20'hC8000, 1'b0, 2'd0, "R7");
    probe_attr(20'hD8000, 1'b0, 2'd0, "R7");
    probe_attr(20'hE0000, 1'b1, 2'd1, "R7");
    probe_attr(20'h80000, 1'b0, 2'd0, "R7");
    probe_bios(1'b0, "R8");
    // Control write in fine mode leaves attributes, but selects ROM base 0xE0000
    cfg_write(8'h22, 16'h0100);
    probe_attr(20'h80000, 1'b0, 2'd0, "R7");
    probe_attr(20'hA0000, 1'b0, 2'd0, "R7");
    probe_bios(1'b0, "R8");
    cfg_write(8'h2E, 16'h1000);
    probe_attr(20'hE7FFF, 1'b0, 2'd0, "R7");
    probe_attr(20'hC0000, 1'b1, 2'd1, "R7");
    probe_bios(1'b1, "R8");

    // Lock in coarse mode
    cfg_write(8'h2C, 16'h0000);
    cfg_write(8'h22, 16'h8201);
    probe_attr(20'hC0000, 1'b0, 2'd2, "R6");
    probe_attr(20'hE0000, 1'b0, 2'd2, "R6");
    probe_attr(20'h80000, 1'b1, 2'd1, "R6");
    probe_bios(1'b1, "R8");
    cfg_write(8'h22, 16'h0008);
    probe_attr(20'h80000, 1'b1, 2'd1, "R6");
    probe_attr(20'hC0000, 1'b0, 2'd2, "R6");
    probe_reg(8'h22, 16'h0008, "R9");
    cfg_write(8'h2C, 16'h0001);
    cfg_write(8'h2E, 16'hFF00);
    probe_attr(20'hC0000, 1'b0, 2'd2, "R6");
    probe_attr(20'hA0000, 1'b1, 2'd1, "R6");
    probe_reg(8'h2E, 16'hFF00, "R9");
    probe_reg(8'h2C, 16'h0001, "R9");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule